// File: doc/BRIEF.md
# Multi-Register Stack Transfer Sequencer

This block is a multi-cycle controller that moves a contiguous run of general registers between the register file and a stack held in memory. It starts from fields that have already been decoded: a push/pop selector, a base register field, a 3-bit count, and the index of the register that serves as the stack pointer. It then works through the run one word at a time. Each word uses a register-file read or write port and one memory access with a request/acknowledge handshake. When the run is finished, the block writes the updated stack pointer back into its register and raises a one-cycle completion pulse.

The run starts at the base field plus one, taken modulo 8. A push walks downward from that register and a pop walks upward from it, so the two are mirror images. Two pop encodings are returns:

- The far return (base 5, count 2, stack register 0) restores registers 6 and 7.
- The interrupt return (base 5, count 3, stack register 0) also restores registers 6 and 7, and sends its third word to a separate interrupt-flag register instead of the register file.

Register 0 is the stack pointer and is never a member of a run.

Top module: `stack_xfer_seq`

## Requirements
- R1: A push of n registers stores register F, F-1, ..., F-n+1 (F = (base+1) mod 8), in that order, at memory addresses S, S-1, ..., S-n+1, where S is the value of the stack-pointer register when the push starts. Every such access has mem_we_o=1.
- R2: A pop of n registers reads addresses S+1, S+2, ..., S+n with mem_we_o=0. It writes each word into register F, F+1, ... in ascending order, and the register-file write happens in the same cycle as that word's acknowledge.
- R3: After a non-empty run, the block writes the stack-pointer register exactly once, in the cycle after the last acknowledge. The value written is S-n for a push and S+n for a pop. done_o is high in the following cycle.
- R4: Each word uses exactly one memory request. mem_req_o, mem_addr_o and mem_we_o hold steady until mem_ack_i is sampled high.
- R5: A count of 0 issues no memory request and no register write. done_o pulses two cycles after the start is accepted.
- R6: A push never includes register 0. The run is clipped to min(count, F) registers, so a base of 7 moves nothing.
- R7: A pop never wraps past register 7. The run is clipped to min(count, 8-F) registers, and it is empty when F is 0. The interrupt return is the only exception.
- R8: The far return (pop, base 5, count 2, stack register 0) restores register 6 from S+1 and register 7 from S+2.
- R9: The interrupt return (pop, base 5, count 3, stack register 0) restores registers 6 and 7 from S+1 and S+2. It loads the low FLAG_W bits of the word at S+3 into irq_flags_o, with a one-cycle irq_flags_ld_o strobe, and does not write that word to the register file.
- R10: While busy_o is high, start_i is ignored. No extra transfer happens, and busy_o falls after the current run.
- R11: done_o is a single-cycle pulse, and busy_o is low and all request and write outputs are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a transfer (accepted when idle) |
| is_pop_i | input | 1 | 1 = pop, 0 = push |
| opa_i | input | 3 | Base register field; run starts at base+1 |
| cnt_i | input | 3 | Number of registers to move |
| opb_i | input | 3 | Index of the stack-pointer register |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rf_rd_idx_o | output | 3 | Register-file read index |
| rf_rd_data_i | input | 16 | Register-file read data (combinational) |
| rf_wr_en_o | output | 1 | Register-file write enable |
| rf_wr_idx_o | output | 3 | Register-file write index |
| rf_wr_data_o | output | 16 | Register-file write data |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | 16 | Memory word address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, valid with acknowledge |
| mem_ack_i | input | 1 | Memory acknowledge |
| irq_flags_ld_o | output | 1 | Strobe: interrupt flags loaded |
| irq_flags_o | output | 4 | Interrupt-flag register |

## Verification
The bench goes after the clipping edges. A push from base 1 with count 5 must stop after register 1; a design that wrapped would store the stack pointer itself. A pop from base 4 with count 6 must stop at register 7; a design that wrapped would write registers 0 and 1 and then corrupt the stack-pointer write-back. The interrupt return is checked for its third word landing in the flag register only, since a design that wrote it to the register file would clobber register 0. Zero-length runs, a start pulsed mid-run, and acknowledge latencies of 0 to 2 cycles expose designs that issue a stray access, restart, or advance the address before the handshake completes.

// File: rtl/stack_xfer_pkg.sv
package stack_xfer_pkg;
   typedef enum logic [2:0] {
      SEQ_IDLE,
      SEQ_LOAD,
      SEQ_XFER,
      SEQ_WB,
      SEQ_DONE
   } seq_state_e;

   // Interrupt-return pop encoding: base field and count
   localparam int unsigned RETI_BASE  = 5;
   localparam int unsigned RETI_COUNT = 3;
endpackage

// File: rtl/stack_xfer_plan.sv
module stack_xfer_plan #(
   parameter int unsigned IDX_W   = 3,
   parameter int unsigned CNT_W   = 3,
   parameter bit          RETI_EN = 1'b1
) (
   input  logic             is_pop_i,
   input  logic [IDX_W-1:0] opa_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [IDX_W-1:0] opb_i,
   output logic [IDX_W-1:0] first_o,
   output logic [CNT_W-1:0] eff_o,
   output logic             reti_o
);
   import stack_xfer_pkg::*;

   localparam int unsigned NREG = 1 << IDX_W;
   localparam int unsigned W    = ((IDX_W > CNT_W) ? IDX_W : CNT_W) + 1;

   logic [W-1:0] cnt_x, first_x, room_x, push_eff, pop_eff;

   assign first_o  = opa_i + IDX_W'(1);
   assign cnt_x    = W'(cnt_i);
   assign first_x  = W'(first_o);
   assign room_x   = (first_o == '0) ? '0 : (W'(NREG) - first_x);
   assign push_eff = (cnt_x < first_x) ? cnt_x : first_x;
   assign pop_eff  = (cnt_x < room_x)  ? cnt_x : room_x;

   generate
      if (RETI_EN) begin : g_reti
         assign reti_o = is_pop_i && (opa_i == IDX_W'(RETI_BASE)) &&
                         (cnt_i == CNT_W'(RETI_COUNT)) && (opb_i == '0);
      end else begin : g_no_reti
         assign reti_o = 1'b0;
      end
   endgenerate

   always_comb begin
      if (reti_o)        eff_o = cnt_i;
      else if (is_pop_i) eff_o = CNT_W'(pop_eff);
      else               eff_o = CNT_W'(push_eff);
   end
endmodule

// File: rtl/stack_xfer_ptr.sv
module stack_xfer_ptr #(
   parameter int unsigned ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] load_val_i,
   input  logic              step_i,
   input  logic              up_i,
   output logic [ADDR_W-1:0] ptr_o,
   output logic [ADDR_W-1:0] addr_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ptr_o <= '0;
      else if (load_i) ptr_o <= load_val_i;
      else if (step_i) ptr_o <= up_i ? ptr_o + ADDR_W'(1) : ptr_o - ADDR_W'(1);
   end

   // Pop pre-increments: it addresses one above the pointer
   assign addr_o = up_i ? ptr_o + ADDR_W'(1) : ptr_o;
endmodule

// File: rtl/stack_xfer_seq.sv
module stack_xfer_seq #(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned IDX_W   = 3,
   parameter int unsigned CNT_W   = 3,
   parameter int unsigned FLAG_W  = 4,
   parameter bit          RETI_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              is_pop_i,
   input  logic [IDX_W-1:0]  opa_i,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic [IDX_W-1:0]  opb_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [IDX_W-1:0]  rf_rd_idx_o,
   input  logic [DATA_W-1:0] rf_rd_data_i,
   output logic              rf_wr_en_o,
   output logic [IDX_W-1:0]  rf_wr_idx_o,
   output logic [DATA_W-1:0] rf_wr_data_o,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   input  logic [DATA_W-1:0] mem_rdata_i,
   input  logic              mem_ack_i,
   output logic              irq_flags_ld_o,
   output logic [FLAG_W-1:0] irq_flags_o
);
   import stack_xfer_pkg::*;

   generate
      if (ADDR_W > DATA_W) begin : g_bad_addr_w
         $error("stack pointer must fit in a register: ADDR_W > DATA_W");
      end
      if (FLAG_W > DATA_W) begin : g_bad_flag_w
         $error("FLAG_W wider than DATA_W");
      end
      if (RETI_EN && (CNT_W < 2)) begin : g_bad_cnt_w
         $error("interrupt return needs CNT_W >= 2");
      end
   endgenerate

   seq_state_e       state_q;
   logic             pop_q, reti_q;
   logic [IDX_W-1:0] opb_q, first_q, cur_idx;
   logic [CNT_W-1:0] eff_q, k_q;
   logic [IDX_W-1:0] plan_first;
   logic [CNT_W-1:0] plan_eff;
   logic             plan_reti;
   logic             hs, last, flag_slot;
   logic [ADDR_W-1:0] ptr, addr;

   stack_xfer_plan #(.IDX_W(IDX_W), .CNT_W(CNT_W), .RETI_EN(RETI_EN)) i_plan (
      .is_pop_i (is_pop_i),
      .opa_i    (opa_i),
      .cnt_i    (cnt_i),
      .opb_i    (opb_i),
      .first_o  (plan_first),
      .eff_o    (plan_eff),
      .reti_o   (plan_reti)
   );

   stack_xfer_ptr #(.ADDR_W(ADDR_W)) i_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (state_q == SEQ_LOAD),
      .load_val_i (ADDR_W'(rf_rd_data_i)),
      .step_i     (hs),
      .up_i       (pop_q),
      .ptr_o      (ptr),
      .addr_o     (addr)
   );

   assign hs        = (state_q == SEQ_XFER) && mem_ack_i;
   assign last      = (k_q == (eff_q - CNT_W'(1)));
   assign flag_slot = reti_q && (k_q == CNT_W'(RETI_COUNT - 1));
   assign cur_idx   = pop_q ? (first_q + IDX_W'(k_q)) : (first_q - IDX_W'(k_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         pop_q   <= 1'b0;
         reti_q  <= 1'b0;
         opb_q   <= '0;
         first_q <= '0;
         eff_q   <= '0;
         k_q     <= '0;
      end else begin
         case (state_q)
            SEQ_IDLE: if (start_i) begin
               pop_q   <= is_pop_i;
               reti_q  <= plan_reti;
               opb_q   <= opb_i;
               first_q <= plan_first;
               eff_q   <= plan_eff;
               k_q     <= '0;
               state_q <= SEQ_LOAD;
            end
            SEQ_LOAD: state_q <= (eff_q == '0) ? SEQ_DONE : SEQ_XFER;
            SEQ_XFER: if (mem_ack_i) begin
               k_q <= k_q + CNT_W'(1);
               if (last) state_q <= SEQ_WB;
            end
            SEQ_WB:   state_q <= SEQ_DONE;
            default:  state_q <= SEQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              irq_flags_o <= '0;
      else if (irq_flags_ld_o) irq_flags_o <= mem_rdata_i[FLAG_W-1:0];
   end

   assign busy_o         = (state_q != SEQ_IDLE);
   assign done_o         = (state_q == SEQ_DONE);
   assign mem_req_o      = (state_q == SEQ_XFER);
   assign mem_we_o       = mem_req_o && !pop_q;
   assign mem_addr_o     = addr;
   assign mem_wdata_o    = rf_rd_data_i;
   assign rf_rd_idx_o    = (state_q == SEQ_LOAD) ? opb_q : cur_idx;
   assign irq_flags_ld_o = hs && pop_q && flag_slot;
   assign rf_wr_en_o     = (state_q == SEQ_WB) || (hs && pop_q && !flag_slot);
   assign rf_wr_idx_o    = (state_q == SEQ_WB) ? opb_q : cur_idx;
   assign rf_wr_data_o   = (state_q == SEQ_WB) ? DATA_W'(ptr) : mem_rdata_i;

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)); // R4
   AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o && mem_ack_i && mem_we_o && !last |=> mem_req_o && (mem_addr_o == $past(mem_addr_o) - ADDR_W'(1))); // R1
   AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o && mem_ack_i && !mem_we_o && !last |=> mem_req_o && (mem_addr_o == $past(mem_addr_o) + ADDR_W'(1))); // R2
   AST_NO_SP_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      rf_wr_en_o && mem_req_o |-> rf_wr_idx_o != '0); // R7
   AST_PUSH_NO_R0: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o && mem_we_o |-> rf_rd_idx_o != '0); // R6
   AST_WB_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o && mem_ack_i && last |=> rf_wr_en_o && !mem_req_o && (rf_wr_idx_o == opb_q)); // R3
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o && !busy_o); // R11
   AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      irq_flags_ld_o |=> irq_flags_o == $past(mem_rdata_i[FLAG_W-1:0])); // R9
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && start_i |=> $stable(opb_q) && $stable(eff_q) && $stable(pop_q)); // R10

   always_comb begin
      if (rst_n) begin
         AST_FLAG_EXCL: assert (!(rf_wr_en_o && irq_flags_ld_o)); // R9
      end
   end
endmodule

// File: tb/test_stack_xfer_seq.sv
`timescale 1ns/1ps
module test_stack_xfer_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        is_pop_i = 1'b0;
   logic [2:0]  opa_i = '0, cnt_i = '0, opb_i = '0;
   logic        busy_o, done_o;
   logic [2:0]  rf_rd_idx_o, rf_wr_idx_o;
   logic [15:0] rf_rd_data_i, rf_wr_data_o;
   logic        rf_wr_en_o, mem_req_o, mem_we_o;
   logic [15:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
   logic        mem_ack_i = 1'b0;
   logic        irq_flags_ld_o;
   logic [3:0]  irq_flags_o;

   logic [15:0] regs [0:7];
   logic [15:0] mem  [0:255];
   int          lat = 0;
   int          wcnt = 0;
   int          n_chk = 0;
   int          n_bad = 0;
   int          n_acc = 0;

   // scoreboard: kind 0 = memory access, 1 = register write, 2 = flag load
   int          q_kind [$];
   logic [15:0] q_a    [$];
   logic [15:0] q_d    [$];
   logic        q_we   [$];
   string       q_tag  [$];

   always #10 clk = ~clk;

   stack_xfer_seq i_stack_xfer_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .is_pop_i(is_pop_i),
      .opa_i(opa_i), .cnt_i(cnt_i), .opb_i(opb_i), .busy_o(busy_o), .done_o(done_o),
      .rf_rd_idx_o(rf_rd_idx_o), .rf_rd_data_i(rf_rd_data_i),
      .rf_wr_en_o(rf_wr_en_o), .rf_wr_idx_o(rf_wr_idx_o), .rf_wr_data_o(rf_wr_data_o),
      .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
      .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ack_i(mem_ack_i),
      .irq_flags_ld_o(irq_flags_ld_o), .irq_flags_o(irq_flags_o)
   );

   assign rf_rd_data_i = regs[rf_rd_idx_o];
   assign mem_rdata_i  = mem[mem_addr_o[7:0]];

   always @(posedge clk) begin
      if (rf_wr_en_o) regs[rf_wr_idx_o] <= rf_wr_data_o;
      if (mem_req_o && mem_ack_i && mem_we_o) mem[mem_addr_o[7:0]] <= mem_wdata_o;
   end

   // memory responder with programmable latency
   always @(posedge clk) begin
      #1;
      if (mem_ack_i) begin
         mem_ack_i = 1'b0;
      end else if (mem_req_o) begin
         if (wcnt >= lat) begin
            mem_ack_i = 1'b1;
            wcnt = 0;
         end else begin
            wcnt++;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic expect_ev(input int kind, input logic [15:0] a, input logic [15:0] d,
                            input logic we, input string tag);
      q_kind.push_back(kind); q_a.push_back(a); q_d.push_back(d);
      q_we.push_back(we); q_tag.push_back(tag);
   endtask

   task automatic pop_ev(input int kind, input logic [15:0] a, input logic [15:0] d, input logic we);
      int          ek;
      logic [15:0] ea, ed;
      logic        ewe;
      string       et;
      if (q_kind.size() == 0) begin
         chk(1'b0, "unexpected event (R5/R10)", a, 16'hxxxx);
         return;
      end
      ek = q_kind.pop_front(); ea = q_a.pop_front(); ed = q_d.pop_front();
      ewe = q_we.pop_front(); et = q_tag.pop_front();
      chk(ek == kind, {et, " kind"}, 16'(kind), 16'(ek));
      chk(a == ea, {et, " addr/index"}, a, ea);
      if (kind != 2) chk(d == ed, {et, " data"}, d, ed);
      if (kind == 0) chk(we == ewe, {et, " we"}, 16'(we), 16'(ewe));
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_req_o && mem_ack_i) begin
            n_acc++;
            pop_ev(0, mem_addr_o, mem_we_o ? mem_wdata_o : mem_rdata_i, mem_we_o);
         end
         if (rf_wr_en_o) pop_ev(1, 16'(rf_wr_idx_o), rf_wr_data_o, 1'b0);
         if (irq_flags_ld_o) pop_ev(2, 16'h0, 16'h0, 1'b0);
      end
   end

   task automatic run(input bit pop, input logic [2:0] opa, input logic [2:0] cnt,
                      input logic [2:0] opb, input int l, input bit glitch, input string tag,
                      output logic [3:0] flag_exp);
      logic [2:0]  first;
      int          eff;
      bit          reti;
      logic [15:0] sp;
      int          acc0;
      bit          seen;
      lat   = l;
      first = opa + 3'd1;
      reti  = pop && opa == 3'd5 && cnt == 3'd3 && opb == 3'd0;
      if (reti)     eff = 3;
      else if (pop) eff = (first == 0) ? 0 : ((int'(cnt) < 8 - int'(first)) ? int'(cnt) : 8 - int'(first));
      else          eff = (int'(cnt) < int'(first)) ? int'(cnt) : int'(first);
      sp = regs[opb];
      flag_exp = irq_flags_o;
      for (int k = 0; k < eff; k++) begin
         if (pop) begin
            logic [15:0] ad, dv;
            ad = sp + 16'(k + 1);
            dv = mem[ad[7:0]];
            expect_ev(0, ad, dv, 1'b0, tag);
            if (reti && k == 2) begin
               expect_ev(2, 16'h0, 16'h0, 1'b0, tag);
               flag_exp = dv[3:0];
            end else begin
               expect_ev(1, 16'(first + 3'(k)), dv, 1'b0, tag);
            end
         end else begin
            logic [15:0] ad;
            logic [2:0]  ri;
            ad = sp - 16'(k);
            ri = first - 3'(k);
            expect_ev(0, ad, regs[ri], 1'b1, tag);
         end
      end
      if (eff > 0) expect_ev(1, 16'(opb), pop ? sp + 16'(eff) : sp - 16'(eff), 1'b0, "R3");
      acc0 = n_acc;
      @(negedge clk);
      start_i = 1'b1; is_pop_i = pop; opa_i = opa; cnt_i = cnt; opb_i = opb;
      @(negedge clk);
      start_i = 1'b0;
      if (glitch) begin
         @(negedge clk);
         start_i = 1'b1; is_pop_i = ~pop; opa_i = 3'd2; cnt_i = 3'd1; opb_i = 3'd3;
         @(negedge clk);
         start_i = 1'b0;
      end
      seen = 1'b0;
      for (int c = 0; c < 300 && !seen; c++) begin
         if (done_o) seen = 1'b1;
         else @(negedge clk);
      end
      chk(seen, {tag, " done seen (R3)"}, 16'(seen), 16'h1);
      @(negedge clk);
      chk(!done_o, "R11 done one cycle", 16'(done_o), 16'h0);
      chk(q_kind.size() == 0, {tag, " all expected events observed"}, 16'(q_kind.size()), 16'h0);
      chk(n_acc - acc0 == eff, {tag, " access count (R4)"}, 16'(n_acc - acc0), 16'(eff));
      q_kind.delete(); q_a.delete(); q_d.delete(); q_we.delete(); q_tag.delete();
   endtask

   initial begin
      logic [3:0] fe;
      for (int i = 0; i < 8; i++) regs[i] = 16'h1100 * 16'(i) + 16'h0011;
      for (int i = 0; i < 256; i++) mem[i] = 16'hA000 ^ 16'(i * 37);
      regs[0] = 16'h0080;
      regs[5] = 16'h00C0;
      repeat (3) @(negedge clk);
      chk(!busy_o, "R11 reset busy", 16'(busy_o), 16'h0);
      chk(!done_o, "R11 reset done", 16'(done_o), 16'h0);
      chk(!mem_req_o, "R11 reset req", 16'(mem_req_o), 16'h0);
      chk(!rf_wr_en_o, "R11 reset rf write", 16'(rf_wr_en_o), 16'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      run(1'b0, 3'd3, 3'd3, 3'd0, 0, 1'b0, "R1 push 4..2", fe);
      chk(regs[0] == 16'h007D, "R3 push final SP", regs[0], 16'h007D);
      regs[2] = 16'h0; regs[3] = 16'h0; regs[4] = 16'h0;
      run(1'b1, 3'd1, 3'd3, 3'd0, 1, 1'b0, "R2 pop 2..4", fe);
      chk(regs[4] == 16'h4411, "R2 pop restores pushed value", regs[4], 16'h4411);
      chk(regs[0] == 16'h0080, "R3 pop final SP", regs[0], 16'h0080);
      run(1'b0, 3'd6, 3'd2, 3'd5, 2, 1'b0, "R1 push alt SP", fe);
      chk(regs[5] == 16'h00BE, "R3 alt SP write-back", regs[5], 16'h00BE);
      run(1'b0, 3'd1, 3'd5, 3'd5, 1, 1'b0, "R6 push clip", fe);
      run(1'b0, 3'd7, 3'd4, 3'd0, 0, 1'b0, "R6 push base 7 empty", fe);
      run(1'b1, 3'd3, 3'd0, 3'd0, 0, 1'b0, "R5 zero count", fe);
      run(1'b1, 3'd4, 3'd6, 3'd1, 1, 1'b0, "R7 pop clip", fe);
      regs[0] = 16'h0030;
      run(1'b1, 3'd5, 3'd2, 3'd0, 0, 1'b0, "R8 far return", fe);
      chk(regs[7] == mem[8'h32], "R8 PC restored", regs[7], mem[8'h32]);
      regs[0] = 16'h0030;
      mem[8'h33] = 16'h5A5B;
      run(1'b1, 3'd5, 3'd3, 3'd0, 2, 1'b0, "R9 interrupt return", fe);
      chk(irq_flags_o == 4'hB, "R9 flag value", 16'(irq_flags_o), 16'h000B);
      chk(regs[0] == 16'h0033, "R9 SP after three words", regs[0], 16'h0033);
      run(1'b0, 3'd4, 3'd3, 3'd0, 2, 1'b1, "R10 start while busy", fe);
      repeat (4) @(negedge clk);
      chk(!busy_o, "R10 no relaunch", 16'(busy_o), 16'h0);
      chk(n_chk >= 12, "check count", 16'(n_chk), 16'd12);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(20 * 50000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule